// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This unit is the write-permission gate of a small serial non-volatile memory. It keeps the write-enable latch and a two-bit block-protect code. It also forms the status byte that the serial front end shifts out. The instruction decoder gives it one-cycle requests to enable, disable or write the status register, and a candidate array write with its 9-bit address. The unit answers in the same cycle whether the array write or the status write may proceed.

The protect code selects one of four protected regions of the array: nothing, the top quarter, the top half, or everything. A hardware write-protect input must be high for any programming. The enable latch drops when that input goes low, when a disable request arrives, and when the external program timer reports that a programming cycle has finished. While a cycle is running, the status byte shows only the ready/busy flag, and every other request is refused.

A refused array write or status write does not change any state. It produces a one-cycle pulse on the cycle after the refused request. The protect bits live in flops, and their reset value is a parameter that stands in for the non-volatile contents.

Top module: `wg_unit`

## Requirements
- R1: After reset the enable latch is clear, the protect code equals the BP_RESET parameter (default 00), both grants are low and the ignored pulse is low.
- R2: An enable request sets the latch on the next clock only when the protect pin is high, busy is low, and no clearing condition is present in the same cycle.
- R3: A disable request clears the latch on the next clock whatever the protect pin level. If an enable and a disable request arrive in the same cycle, the disable wins.
- R4: A low level on the protect pin clears the latch on the next clock.
- R5: A cycle-done pulse clears the latch on the next clock.
- R6: Protect code 00 protects nothing, 01 protects addresses 0x180–0x1FF, 10 protects 0x100–0x1FF and 11 protects 0x000–0x1FF. A write to a protected address is never granted.
- R7: The write grant is high in the same cycle as an array write request exactly when the protect pin is high, the latch is set, busy is low and the address is unprotected.
- R8: The status-write grant is high exactly when a status write is requested with the protect pin high, the latch set and busy low. On a grant the protect code takes data bits 3:2 (bit 3 is the high code bit) on the next clock. Data bits 7:4 and 1:0 have no effect.
- R9: While not busy, the status byte is {0000, code[1], code[0], latch, 0}, with bit 0 the ready/busy flag.
- R10: While busy, the status byte reads 0xFF.
- R11: A refused array write or status write drives the ignored output high for exactly the next cycle and leaves latch and code unchanged.
- R12: While busy, enable, disable, array write and status write requests have no effect. The protect-pin and cycle-done clears still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_wren | input | 1 | Enable-latch set request (one cycle) |
| op_wrdi | input | 1 | Enable-latch clear request (one cycle) |
| op_wrsr | input | 1 | Status-register write request (one cycle) |
| op_write | input | 1 | Array write request (one cycle) |
| wp_hi | input | 1 | Write-protect pin level; high permits programming |
| busy | input | 1 | Program cycle in progress |
| cycle_done | input | 1 | Program cycle completed (one cycle) |
| wr_addr | input | ADDR_W | Candidate array write address |
| sr_wdata | input | 8 | Data byte of a status write |
| status_byte | output | 8 | Status byte for readout |
| write_grant | output | 1 | Array write permitted this cycle |
| sr_grant | output | 1 | Status write permitted this cycle |
| req_ignored | output | 1 | One-cycle pulse after a refused write |

## Verification
A stale or wrongly set enable latch shows up in status bit 1 as soon as the request is idle. It also changes the write and status-write grants, which are combinational, in the very next cycle that carries a request. A wrong protect code appears in status bits 3:2 one clock after the status write. It shows up in the grant for any address that crosses the 0x100 or 0x180 boundary. The bench aims its directed cases at exactly those boundaries and at clear/set collisions. Random traffic then compares every output, every cycle, against a reference model.

// File: rtl/wg_pkg.sv
package wg_pkg;
   localparam int STATUS_W = 8;
   localparam int POS_RDY  = 0;
   localparam int POS_WEN  = 1;
   localparam int POS_BP0  = 2;
   localparam int POS_BP1  = 3;

   typedef enum logic [1:0] {
      BP_NONE    = 2'b00,
      BP_QUARTER = 2'b01,
      BP_HALF    = 2'b10,
      BP_ALL     = 2'b11
   } bp_level_e;
endpackage

// File: rtl/wg_enable_latch.sv
module wg_enable_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic wp_hi,
   input  logic busy,
   input  logic op_wren,
   input  logic op_wrdi,
   input  logic cycle_done,
   output logic wen_q
);
   logic hard_clear;
   logic soft_clear;
   logic soft_set;

   assign hard_clear = !wp_hi || cycle_done;
   assign soft_clear = !busy && op_wrdi;
   assign soft_set   = !busy && op_wren;

   always_ff @(posedge clk) begin
      if (!rst_n)          wen_q <= 1'b0;
      else if (hard_clear) wen_q <= 1'b0;
      else if (soft_clear) wen_q <= 1'b0;
      else if (soft_set)   wen_q <= 1'b1;
   end

   a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wren && wp_hi && !busy && !op_wrdi && !cycle_done) |=> wen_q);
   a_r3_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wrdi && !busy) |=> !wen_q);
   a_r4_wp_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_hi |=> !wen_q);
   a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |=> !wen_q);
endmodule

// File: rtl/wg_prot_range.sv
module wg_prot_range
   import wg_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  bp_level_e          level,
   input  logic [ADDR_W-1:0]  addr,
   output logic               in_prot
);
   localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W - 1);
   localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(3) << (ADDR_W - 2);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("wg_prot_range: ADDR_W must be at least 2");
      end
   endgenerate

   always_comb begin
      unique case (level)
         BP_NONE:    in_prot = 1'b0;
         BP_QUARTER: in_prot = (addr >= QUARTER_BASE);
         BP_HALF:    in_prot = (addr >= HALF_BASE);
         BP_ALL:     in_prot = 1'b1;
         default:    in_prot = 1'b1;
      endcase
   end
endmodule

// File: rtl/wg_status_fmt.sv
module wg_status_fmt
   import wg_pkg::*;
(
   input  logic                busy,
   input  bp_level_e           level,
   input  logic                wen_q,
   output logic [STATUS_W-1:0] status_byte
);
   always_comb begin
      if (busy) begin
         status_byte = '1;
      end else begin
         status_byte          = '0;
         status_byte[POS_RDY] = 1'b0;
         status_byte[POS_WEN] = wen_q;
         status_byte[POS_BP0] = level[0];
         status_byte[POS_BP1] = level[1];
      end
   end
endmodule

// File: rtl/wg_unit.sv
module wg_unit
   import wg_pkg::*;
#(
   parameter int         ADDR_W   = 9,
   parameter logic [1:0] BP_RESET = 2'b00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_wren,
   input  logic              op_wrdi,
   input  logic              op_wrsr,
   input  logic              op_write,
   input  logic              wp_hi,
   input  logic              busy,
   input  logic              cycle_done,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        sr_wdata,
   output logic [7:0]        status_byte,
   output logic              write_grant,
   output logic              sr_grant,
   output logic              req_ignored
);
   generate
      if (STATUS_W != 8) begin : g_bad_status
         $error("wg_unit: status byte must be 8 bits wide");
      end
   endgenerate

   logic      wen_q;
   logic      in_prot;
   logic      can_prog;
   logic      denied;
   bp_level_e bp_q;
   logic      unused_sr_bits;

   assign unused_sr_bits = ^{sr_wdata[7:4], sr_wdata[1:0]};

   wg_enable_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wp_hi      (wp_hi),
      .busy       (busy),
      .op_wren    (op_wren),
      .op_wrdi    (op_wrdi),
      .cycle_done (cycle_done),
      .wen_q      (wen_q)
   );

   wg_prot_range #(.ADDR_W(ADDR_W)) u_range (
      .level   (bp_q),
      .addr    (wr_addr),
      .in_prot (in_prot)
   );

   wg_status_fmt u_status (
      .busy        (busy),
      .level       (bp_q),
      .wen_q       (wen_q),
      .status_byte (status_byte)
   );

   assign can_prog    = wp_hi && wen_q && !busy;
   assign write_grant = op_write && can_prog && !in_prot;
   assign sr_grant    = op_wrsr && can_prog;
   assign denied      = (op_write && !write_grant) || (op_wrsr && !sr_grant);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bp_q        <= bp_level_e'(BP_RESET);
         req_ignored <= 1'b0;
      end else begin
         if (sr_grant) bp_q <= bp_level_e'(sr_wdata[POS_BP1:POS_BP0]);
         req_ignored <= denied;
      end
   end

   a_r6_grant_outside: assert property (@(posedge clk) disable iff (!rst_n)
      write_grant |-> !in_prot);
   a_r7_grant_terms: assert property (@(posedge clk) disable iff (!rst_n)
      write_grant |-> (wen_q && wp_hi && !busy));
   a_r8_bp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sr_grant |=> $stable(bp_q));
   a_r8_bp_load: assert property (@(posedge clk) disable iff (!rst_n)
      sr_grant |=> (bp_q == $past(sr_wdata[3:2])));
   a_r10_busy_ones: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (status_byte == 8'hFF));
   a_r11_ignored_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_write && !write_grant) || (op_wrsr && !sr_grant)) |=> req_ignored);
   a_r12_busy_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!write_grant && !sr_grant));
endmodule

// File: tb/sim_wg_unit.sv
`timescale 1ns/1ps
module sim_wg_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_wren = 0, op_wrdi = 0, op_wrsr = 0, op_write = 0;
   logic       wp_hi = 1, busy = 0, cycle_done = 0;
   logic [8:0] wr_addr = '0;
   logic [7:0] sr_wdata = '0;
   logic [7:0] status_byte;
   logic       write_grant, sr_grant, req_ignored;

   int total = 0;
   int bad = 0;

   logic       m_wen;
   logic [1:0] m_bp;
   logic       m_ign;

   always #2.5 clk = ~clk;

   wg_unit #(.ADDR_W(9), .BP_RESET(2'b00)) u0 (
      .clk(clk), .rst_n(rst_n), .op_wren(op_wren), .op_wrdi(op_wrdi),
      .op_wrsr(op_wrsr), .op_write(op_write), .wp_hi(wp_hi), .busy(busy),
      .cycle_done(cycle_done), .wr_addr(wr_addr), .sr_wdata(sr_wdata),
      .status_byte(status_byte), .write_grant(write_grant),
      .sr_grant(sr_grant), .req_ignored(req_ignored)
   );

   function automatic logic prot(input logic [1:0] bp, input logic [8:0] a);
      case (bp)
         2'b00:   return 1'b0;
         2'b01:   return a >= 9'h180;
         2'b10:   return a >= 9'h100;
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [7:0] exp_status(input logic b, input logic [1:0] bp, input logic w);
      return b ? 8'hFF : {4'b0000, bp, w, 1'b0};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Drive one cycle at the negative edge, check outputs, update the model at the posedge.
   task automatic step(input string tag, input logic wren, input logic wrdi,
                       input logic wrsr, input logic wr, input logic wp,
                       input logic bz, input logic dn, input logic [8:0] a,
                       input logic [7:0] d);
      logic e_wok, e_sok;
      op_wren = wren; op_wrdi = wrdi; op_wrsr = wrsr; op_write = wr;
      wp_hi = wp; busy = bz; cycle_done = dn; wr_addr = a; sr_wdata = d;
      #1;
      e_wok = wr && wp && m_wen && !bz && !prot(m_bp, a);
      e_sok = wrsr && wp && m_wen && !bz;
      check((tag != "") ? tag : "R7", {7'd0, write_grant}, {7'd0, e_wok});
      check((tag != "") ? tag : "R8", {7'd0, sr_grant}, {7'd0, e_sok});
      check((tag != "") ? tag : (bz ? "R10" : "R9"), status_byte, exp_status(bz, m_bp, m_wen));
      check((tag != "") ? tag : "R11", {7'd0, req_ignored}, {7'd0, m_ign});
      @(posedge clk);
      m_ign = (wr && !e_wok) || (wrsr && !e_sok);
      if (e_sok) m_bp = d[3:2];
      if (!wp || dn) m_wen = 1'b0;
      else if (!bz && wrdi) m_wen = 1'b0;
      else if (!bz && wren) m_wen = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      step(tag, 0, 0, 0, 0, 1, 0, 0, 9'h000, 8'h00);
   endtask

   initial begin
      #(5.0 * 200000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_wen = 0; m_bp = 2'b00; m_ign = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check("R1", status_byte, 8'h00);
      check("R1", {6'd0, write_grant, sr_grant}, 8'h00);
      check("R1", {7'd0, req_ignored}, 8'h00);
      @(negedge clk);

      // R2: enable refused with protect pin low, accepted with it high
      step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R2", status_byte, 8'h00);
      step("R2", 1, 0, 0, 0, 1, 0, 0, 0, 0);
      idle("R2"); check("R2", status_byte, 8'h02);
      // R3: disable clears; disable beats enable in the same cycle
      step("R3", 0, 1, 0, 0, 1, 0, 0, 0, 0);
      check("R3", status_byte, 8'h00);
      step("R3", 1, 0, 0, 0, 1, 0, 0, 0, 0);
      step("R3", 1, 1, 0, 0, 1, 0, 0, 0, 0);
      check("R3", status_byte, 8'h00);
      // R4: protect pin low clears
      step("R4", 1, 0, 0, 0, 1, 0, 0, 0, 0);
      step("R4", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      idle("R4"); check("R4", status_byte, 8'h00);
      // R5: cycle done clears
      step("R5", 1, 0, 0, 0, 1, 0, 0, 0, 0);
      step("R5", 0, 0, 0, 0, 1, 0, 1, 0, 0);
      check("R5", status_byte, 8'h00);
      // R8: status write takes bits 3:2 only (0xF7 -> code 01)
      step("R8", 1, 0, 0, 0, 1, 0, 0, 0, 0);
      step("R8", 0, 0, 1, 0, 1, 0, 0, 0, 8'hF7);
      check("R8", status_byte, 8'h06);
      step("R8", 0, 0, 0, 0, 1, 0, 1, 0, 0);
      check("R8", status_byte, 8'h04);
      // R6: quarter boundary with code 01
      step("R6", 1, 0, 0, 0, 1, 0, 0, 0, 0);
      step("R6", 0, 0, 0, 1, 1, 0, 0, 9'h17F, 0);
      step("R6", 0, 0, 0, 1, 1, 0, 0, 9'h180, 0);
      // R11: refused write pulses ignored for one cycle
      check("R11", {7'd0, req_ignored}, 8'h01);
      idle("R11");
      check("R11", {7'd0, req_ignored}, 8'h00);
      check("R11", status_byte, 8'h06);
      // R10/R12: busy reads all ones and blocks requests
      step("R10", 0, 0, 0, 0, 1, 0, 1, 0, 0);
      step("R10", 1, 0, 0, 0, 1, 1, 0, 0, 0);
      idle("R12"); check("R12", status_byte, 8'h04);
      step("R12", 1, 0, 0, 0, 1, 0, 0, 0, 0);
      step("R12", 0, 1, 1, 1, 1, 1, 0, 9'h000, 8'h0C);
      idle("R12"); check("R12", status_byte, 8'h06);

      // Random traffic against the model
      for (int i = 0; i < 6000; i++) begin
         logic [3:0] op;
         logic wr_en, wr_di, wr_sr, wr_ar, wp, bz, dn;
         op = 4'($urandom_range(0, 9));
         wr_en = (op == 0) || (op == 5);
         wr_di = (op == 1);
         wr_sr = (op == 2);
         wr_ar = (op == 3) || (op == 4) || (op == 6);
         wp = ($urandom_range(0, 15) != 0);
         bz = ($urandom_range(0, 5) == 0);
         dn = ($urandom_range(0, 19) == 0);
         step("", wr_en, wr_di, wr_sr, wr_ar, wp, bz, dn,
              9'($urandom_range(0, 511)), 8'($urandom_range(0, 255)));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule